// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block moves bytes between a processor register bus and two 8-bit peripheral ports under control of a strobe pair per port. Each port has a control input from the peripheral and a control output to it. Port A can handshake on processor reads and on processor writes. Port B handshakes only on processor writes. An edge of the chosen polarity on a control input sets that port's flag. In level mode the same edge also returns the control output high. A processor access to the port's data register drives the control output low, either until that edge arrives (level mode) or for exactly one clock (pulse mode).

The processor programs the line modes through a control register at index 12. It reads the two flags from a status register and gates them with an enable mask. The active-low interrupt output is registered. It is low while any enabled flag is set. Reading or writing a port's data register clears that port's flag. Control inputs pass through a two-stage synchroniser before edge detection.

Top module: `hsk_port_ctrl`

## Requirements
- R1: After a synchronous reset, both control outputs and `irq_n` are high, the control, mask and flag registers read 0, and both port output latches are 0.
- R2: Register index 12 is the control register and reads back what was written. Bit 0 selects the port A input edge (0 falling, 1 rising). Bits 3:1 hold the port A output mode. Bit 4 selects the port B input edge. Bits 7:5 hold the port B output mode. Mode code 100 is level handshake and 101 is one-cycle pulse.
- R3: A transition of the selected polarity on a control input sets that port's flag on the third rising clock edge after the input changes. A transition of the other polarity sets nothing.
- R4: In level mode, a port A data read (index 1) or data write drives `a_ctl_out` low from the access edge. It stays low until an active edge on `a_ctl_in`, which returns it high on the same clock that the flag sets.
- R5: In pulse mode, a data access drives the control output low for exactly the one cycle after the access edge.
- R6: Only a write of port B data (index 0) asserts `b_ctl_out`. A read of index 0 leaves it high.
- R7: A read or write of a port's data register clears that port's flag. If an active input edge lands on the same clock, the flag ends up set.
- R8: Flags read at index 13 (bit 0 port A, bit 1 port B) and the enable mask sits at index 14 (same bit order). `irq_n` is low exactly when a flag and its mask bit are both set, and it follows the flag on the same clock.
- R9: A write to index 1 loads `pa_out` and a write to index 0 loads `pb_out`. A read of index 1 returns `pa_in`. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`.
- R10: When a control output's mode code is neither 100 nor 101, that output stays high whatever accesses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| a_ctl_in | input | 1 | Port A strobe from the peripheral |
| a_ctl_out | output | 1 | Port A strobe to the peripheral |
| b_ctl_in | input | 1 | Port B strobe from the peripheral |
| b_ctl_out | output | 1 | Port B strobe to the peripheral |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume a read strobe and a write strobe never arrive on the same clock. They also assume the control inputs are high through reset, so the synchroniser's idle-high reset value creates no false edge. The stimulus meets both: every bus access is a one-cycle strobe driven on the falling clock edge, and the strobe lines start high and change only after the matching control register value is in place. The case where a flag is set and cleared on the same clock is built by timing a read strobe to hit the clock on which the synchronised edge is detected.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_LEVEL = 2'd1,
    CTL_PULSE = 2'd2
  } ctl_mode_e;

  localparam logic [2:0] CODE_LEVEL = 3'b100;
  localparam logic [2:0] CODE_PULSE = 3'b101;

  // one nibble of the control register: {mode[2:0], rise}
  typedef struct packed {
    logic [2:0] mode;
    logic       rise;
  } line_cfg_t;

  function automatic ctl_mode_e decode_mode(input logic [2:0] code);
    case (code)
      CODE_LEVEL: decode_mode = CTL_LEVEL;
      CODE_PULSE: decode_mode = CTL_PULSE;
      default:    decode_mode = CTL_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/hsk_edge_sync.sv
module hsk_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);

  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {(STAGES+1){IDLE}};
    else     chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  logic synced, hist;
  assign synced = chain_q[STAGES-1];
  assign hist   = chain_q[STAGES];

  always_comb begin
    if (rise_sel_i) edge_o = synced & ~hist;
    else            edge_o = ~synced & hist;
  end

endmodule

// File: rtl/hsk_line.sv
module hsk_line
  import hsk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ctl_mode_e mode_i,
  input  logic      trig_i,
  input  logic      edge_i,
  input  logic      clr_i,
  output logic      ctl_o,
  output logic      flag_o,
  output logic      flag_nxt_o
);

  logic ctl_nxt;

  // a new edge outranks a clearing access
  always_comb begin
    if (edge_i)     flag_nxt_o = 1'b1;
    else if (clr_i) flag_nxt_o = 1'b0;
    else            flag_nxt_o = flag_o;
  end

  always_comb begin
    case (mode_i)
      CTL_LEVEL: begin
        if (trig_i)      ctl_nxt = 1'b0;
        else if (edge_i) ctl_nxt = 1'b1;
        else             ctl_nxt = ctl_o;
      end
      CTL_PULSE: ctl_nxt = ~trig_i;
      default:   ctl_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o  <= 1'b1;
      flag_o <= 1'b0;
    end else begin
      ctl_o  <= ctl_nxt;
      flag_o <= flag_nxt_o;
    end
  end

  assert_flag_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> flag_o);

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CTL_LEVEL && !ctl_o && !edge_i) |=> !ctl_o);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CTL_PULSE && !ctl_o && !trig_i) |=> ctl_o);

  assert_clear_on_access_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !edge_i) |=> !flag_o);

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CTL_IDLE) |=> ctl_o);

endmodule

// File: rtl/hsk_port_ctrl.sv
module hsk_port_ctrl
  import hsk_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_PB      = 0,
  parameter int IDX_PA      = 1,
  parameter int IDX_CTRL    = 12,
  parameter int IDX_FLAG    = 13,
  parameter int IDX_MASK    = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pb_out,
  input  logic          a_ctl_in,
  output logic          a_ctl_out,
  input  logic          b_ctl_in,
  output logic          b_ctl_out,
  output logic          irq_n
);

  localparam int NPORT = 2;
  localparam int CFG_W = $bits(line_cfg_t);

  logic [DW-1:0]    ctrl_q;
  logic [NPORT-1:0] mask_q, mask_nxt;
  logic [NPORT-1:0] flag_q, flag_nxt;
  logic [NPORT-1:0] pin_in, ctl_out, edge_det, trig, clr;

  logic acc_pa, acc_pb, wr_pa, wr_pb, wr_ctrl, wr_mask;
  assign acc_pa  = (bus_rd | bus_wr) && bus_sel == AW'(IDX_PA);
  assign acc_pb  = (bus_rd | bus_wr) && bus_sel == AW'(IDX_PB);
  assign wr_pa   = bus_wr && bus_sel == AW'(IDX_PA);
  assign wr_pb   = bus_wr && bus_sel == AW'(IDX_PB);
  assign wr_ctrl = bus_wr && bus_sel == AW'(IDX_CTRL);
  assign wr_mask = bus_wr && bus_sel == AW'(IDX_MASK);

  // port A handshakes on reads and writes, port B on writes only
  assign trig = {wr_pb, acc_pa};
  assign clr  = {acc_pb, acc_pa};
  assign pin_in = {b_ctl_in, a_ctl_in};
  assign mask_nxt = wr_mask ? bus_wdata[NPORT-1:0] : mask_q;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_line
      line_cfg_t cfg;
      assign cfg = line_cfg_t'(ctrl_q[p*CFG_W +: CFG_W]);

      hsk_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pin_in[p]),
        .rise_sel_i (cfg.rise),
        .edge_o     (edge_det[p])
      );

      hsk_line u_line (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (decode_mode(cfg.mode)),
        .trig_i     (trig[p]),
        .edge_i     (edge_det[p]),
        .clr_i      (clr[p]),
        .ctl_o      (ctl_out[p]),
        .flag_o     (flag_q[p]),
        .flag_nxt_o (flag_nxt[p])
      );
    end
  endgenerate

  assign a_ctl_out = ctl_out[0];
  assign b_ctl_out = ctl_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mask_q    <= '0;
      pa_out    <= '0;
      pb_out    <= '0;
      bus_rdata <= '0;
      irq_n     <= 1'b1;
    end else begin
      mask_q <= mask_nxt;
      irq_n  <= ~|(flag_nxt & mask_nxt);
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_pa)   pa_out <= bus_wdata;
      if (wr_pb)   pb_out <= bus_wdata;
      if (bus_rd) begin
        if (bus_sel == AW'(IDX_PB))        bus_rdata <= pb_out;
        else if (bus_sel == AW'(IDX_PA))   bus_rdata <= pa_in;
        else if (bus_sel == AW'(IDX_CTRL)) bus_rdata <= ctrl_q;
        else if (bus_sel == AW'(IDX_FLAG)) bus_rdata <= DW'(flag_q);
        else if (bus_sel == AW'(IDX_MASK)) bus_rdata <= DW'(mask_q);
        else                               bus_rdata <= '0;
      end
    end
  end

  // input assumption: one strobe per access
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  assert_irq_tracks_flags_R8: assert property (@(posedge clk) disable iff (rst)
    irq_n == ~|(flag_q & mask_q));

  assert_b_read_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel == AW'(IDX_PB) && b_ctl_out) |=> b_ctl_out);

endmodule

// File: tb/hsk_port_ctrl_test.sv
module hsk_port_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_sel = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pa_out, pb_out;
  logic [7:0] pa_in = 8'hC3;
  logic       a_ctl_in = 1'b1, b_ctl_in = 1'b1;
  logic       a_ctl_out, b_ctl_out, irq_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hsk_port_ctrl uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_in(pa_in),
    .pa_out(pa_out), .pb_out(pb_out), .a_ctl_in(a_ctl_in),
    .a_ctl_out(a_ctl_out), .b_ctl_in(b_ctl_in), .b_ctl_out(b_ctl_out),
    .irq_n(irq_n)
  );

  // {is_write, index, data_or_expected}
  localparam int NVEC = 8;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 4'd12, 8'h00, 4'd0},
    {1'b1, 4'd14, 8'h03, 4'd0},
    {1'b0, 4'd14, 8'h03, 4'd0},
    {1'b1, 4'd12, 8'hA5, 4'd0},
    {1'b0, 4'd12, 8'hA5, 4'd0},
    {1'b0, 4'd13, 8'h00, 4'd0},
    {1'b0, 4'd1,  8'hC3, 4'd0},
    {1'b0, 4'd15, 8'h00, 4'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_write(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    bus_sel = idx; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] idx);
    @(negedge clk);
    bus_sel = idx; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cycles(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 a_ctl_out", {7'd0, a_ctl_out}, 8'h01);
    check("R1 b_ctl_out", {7'd0, b_ctl_out}, 8'h01);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);

    // table walk: R1/R2/R8/R9 register behaviour
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][16]) bus_write(VEC[v][15:12], VEC[v][11:4]);
      else begin
        bus_read(VEC[v][15:12]);
        check($sformatf("R2/R8/R9 vector %0d", v), bus_rdata, VEC[v][11:4]);
      end
    end

    // R10: mode codes other than 100/101 keep outputs high
    bus_write(4'd12, 8'h04);
    bus_write(4'd1, 8'h11);
    check("R10 a idle after write", {7'd0, a_ctl_out}, 8'h01);
    wait_cycles(1);
    check("R10 a idle next cycle", {7'd0, a_ctl_out}, 8'h01);

    // R4/R3: A level, falling edge; B level, falling edge
    bus_write(4'd12, 8'h88);
    bus_read(4'd1);
    check("R4 a low after read", {7'd0, a_ctl_out}, 8'h00);
    check("R9 read returns pa_in", bus_rdata, 8'hC3);
    a_ctl_in = 1'b0;
    wait_cycles(2);
    check("R3 flag not yet after two edges", {7'd0, irq_n}, 8'h01);
    check("R4 a still low", {7'd0, a_ctl_out}, 8'h00);
    wait_cycles(1);
    check("R4 a released by edge", {7'd0, a_ctl_out}, 8'h01);
    check("R3 irq on third edge", {7'd0, irq_n}, 8'h00);
    a_ctl_in = 1'b1;
    wait_cycles(4);
    bus_read(4'd13);
    check("R8 flag register A", bus_rdata, 8'h01);
    bus_write(4'd1, 8'h77);
    check("R7 write clears flag", {7'd0, irq_n}, 8'h01);
    check("R4 a low after write", {7'd0, a_ctl_out}, 8'h00);
    check("R9 pa_out latched", pa_out, 8'h77);

    // R3 polarity: rising selected, falling ignored
    bus_write(4'd12, 8'h89);
    a_ctl_in = 1'b0;
    wait_cycles(4);
    check("R3 wrong edge no flag", {7'd0, irq_n}, 8'h01);
    check("R3 wrong edge keeps a low", {7'd0, a_ctl_out}, 8'h00);
    a_ctl_in = 1'b1;
    wait_cycles(3);
    check("R3 rising edge sets flag", {7'd0, irq_n}, 8'h00);
    check("R3 rising edge releases a", {7'd0, a_ctl_out}, 8'h01);

    // R6: port B read does not strobe, write does
    bus_read(4'd0);
    check("R6 b high after read", {7'd0, b_ctl_out}, 8'h01);
    wait_cycles(1);
    check("R6 b still high", {7'd0, b_ctl_out}, 8'h01);
    bus_write(4'd0, 8'h5A);
    check("R6 b low after write", {7'd0, b_ctl_out}, 8'h00);
    check("R9 pb_out latched", pb_out, 8'h5A);
    b_ctl_in = 1'b0;
    wait_cycles(3);
    check("R4 b released by edge", {7'd0, b_ctl_out}, 8'h01);
    bus_read(4'd13);
    check("R8 both flags", bus_rdata, 8'h03);
    b_ctl_in = 1'b1;
    wait_cycles(4);

    // R8: mask gating
    bus_write(4'd14, 8'h02);
    check("R8 B enabled irq low", {7'd0, irq_n}, 8'h00);
    bus_write(4'd0, 8'h5B);
    check("R8 A masked irq high", {7'd0, irq_n}, 8'h01);
    bus_write(4'd14, 8'h01);
    check("R8 A unmasked irq low", {7'd0, irq_n}, 8'h00);

    // R5: pulse mode on both lines
    bus_write(4'd12, 8'hAB);
    wait_cycles(1);
    bus_write(4'd1, 8'h01);
    check("R5 a pulse low", {7'd0, a_ctl_out}, 8'h00);
    wait_cycles(1);
    check("R5 a pulse ends", {7'd0, a_ctl_out}, 8'h01);
    bus_write(4'd0, 8'h02);
    check("R5 b pulse low", {7'd0, b_ctl_out}, 8'h00);
    wait_cycles(1);
    check("R5 b pulse ends", {7'd0, b_ctl_out}, 8'h01);
    bus_read(4'd0);
    check("R6 b no pulse on read", {7'd0, b_ctl_out}, 8'h01);

    // R7: edge and clearing read on the same clock, set wins
    bus_write(4'd12, 8'h88);
    bus_read(4'd1);
    check("R7 read clears A", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    a_ctl_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 4'd1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R7 set wins over clear", {7'd0, irq_n}, 8'h00);
    check("R4 access wins output low", {7'd0, a_ctl_out}, 8'h00);

    finish_run();
  end

endmodule